// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block controls copies between a volatile SRAM array and the nonvolatile shadow array behind it. It takes level-sensitive software store and recall requests, a hardware store request line, and a flag that reports whether the supply is above the switch threshold. It drives three mutually exclusive array strobes: clear the SRAM, copy the nonvolatile image into the SRAM, and copy the SRAM into the nonvolatile image. A busy output tells the bus logic to refuse external reads and writes while a transfer runs.

After reset the sequencer waits for the supply flag. When the flag rises it runs an automatic recall. A recall has two timed phases: the SRAM is cleared first, then the nonvolatile image is loaded. If the supply drops during this power-up recall, the sequencer goes back to waiting and restarts the whole recall when the supply returns. If a write is still active in the last transfer cycle of the power-up recall, the block raises a one-cycle corruption flag.

Each timed phase lasts a set number of cycles, given by a parameter and counted by a loadable down-counter. After any operation, and after a refused store, no new operation is accepted until every request line has gone low again. This stops a request held high from triggering repeated stores.

Top module: `nvs_seq_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, busy is 1 and all three strobes and write_corrupt are 0.
- R2: In the power-up wait, busy is 1 with no strobe until supply_ok is seen high. After that, clear_stb is high for CLEAR_CYC cycles, then recall_stb for XFER_CYC cycles, with busy held high throughout. Busy then falls.
- R3: If supply_ok is low during the clear or transfer phase of the power-up recall, the sequencer returns to the power-up wait (busy 1, no strobe). When supply_ok returns it restarts with a full CLEAR_CYC clear phase.
- R4: A store request seen in idle while supply_ok is 0 starts no store. No strobe is asserted and busy stays 0.
- R5: write_corrupt is 1 for exactly the one cycle after a power-up recall ends, and only if ext_we was 1 during the last recall_stb cycle. A recall started by software never raises it.
- R6: A store started from idle drives store_stb and busy high for exactly STORE_CYC cycles. Busy then falls.
- R7: After any operation, or a refused store, no operation starts until all three request lines have been low for at least one cycle, even if a request stays high throughout.
- R8: Requests that arrive while busy is 1 are dropped and never start an operation later.
- R9: A software recall runs CLEAR_CYC cycles of clear_stb, then XFER_CYC cycles of recall_stb, with busy high. It never asserts store_stb and may be repeated any number of times.
- R10: A hardware or software store request gives the same store. When a store and a recall are requested in the same idle cycle, the store wins.
- R11: At most one of clear_stb, recall_stb and store_stb is high in any cycle, and every strobe implies busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_store_req | input | 1 | Software store request, level |
| sw_recall_req | input | 1 | Software recall request, level |
| hw_store_req | input | 1 | Hardware store request, level |
| supply_ok | input | 1 | Supply above switch threshold |
| ext_we | input | 1 | External write enable, watched at power-up recall end |
| busy | output | 1 | Blocks external SRAM access |
| clear_stb | output | 1 | Clear SRAM array |
| recall_stb | output | 1 | Copy nonvolatile image into SRAM |
| store_stb | output | 1 | Copy SRAM into nonvolatile image |
| write_corrupt | output | 1 | One-cycle flag: write active as power-up recall ended |

## Verification
The assertions assume that supply_ok and the request lines are synchronous to clk and settle before each edge. They also assume that no store is expected unless supply_ok was high in the idle cycle that accepted it. The bench changes every input only on the falling clock edge. It holds supply_ok steady during every store and software recall, and lowers it only in the power-up recall or while idle. Requests that overlap a busy phase, and a store and a recall raised together, are driven on purpose so that the dropping and priority rules are exercised within those assumptions.

// File: rtl/nvs_pkg.sv
// Package: shared types for the nonvolatile store/recall sequencer.
// Assumes: nothing beyond IEEE 1800-2017 packed types.
package nvs_pkg;

    // Sequencer states; PWR_WAIT is the reset-wait before power-up recall.
    typedef enum logic [2:0] {
        ST_PWR_WAIT = 3'd0,
        ST_IDLE     = 3'd1,
        ST_CLEAR    = 3'd2,
        ST_XFER     = 3'd3,
        ST_STORE    = 3'd4,
        ST_WAIT_REL = 3'd5
    } nvs_state_e;

    // Decoded request intent for one idle cycle.
    typedef struct packed {
        logic any_req;
        logic go_store;
        logic go_recall;
        logic drop_store;
    } nvs_req_t;

endpackage

// File: rtl/nvs_req_qual.sv
// Module: nvs_req_qual
// Sorts the three request levels into one intent per cycle. A store beats
// a recall. A store with the supply low becomes a drop, which the sequencer
// uses to wait for release.
// Assumes: the inputs are synchronous levels; edge handling lives in the FSM.
module nvs_req_qual
    import nvs_pkg::*;
(
    input  logic     sw_store_req,
    input  logic     sw_recall_req,
    input  logic     hw_store_req,
    input  logic     supply_ok,
    output nvs_req_t req
);

    logic store_any;

    // Combine the two store sources and apply priority and supply inhibit.
    always_comb begin
        store_any      = sw_store_req | hw_store_req;
        req.any_req    = store_any | sw_recall_req;
        req.go_store   = store_any & supply_ok;
        req.drop_store = store_any & ~supply_ok;
        req.go_recall  = sw_recall_req & ~store_any;
    end

endmodule

// File: rtl/nvs_timer.sv
// Module: nvs_timer
// Loadable down-counter that times one phase. Loading N-1 on entry to a
// phase makes zero go high in the phase's last cycle.
// Assumes: load is asserted only in the cycle that enters a timed phase.
module nvs_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    // Load on phase entry, otherwise count down and hold at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Flag the final cycle of the phase.
    always_comb zero = (cnt_q == '0);

endmodule

// File: rtl/nvs_fsm.sv
// Module: nvs_fsm
// State machine for power-up wait, idle, the two-phase recall, store and
// release wait. It decides when the phase timer loads and what it loads,
// and reports the end of a power-up recall that was not aborted.
// Assumes: tmr_zero comes from an nvs_timer driven by load/load_val.
module nvs_fsm
    import nvs_pkg::*;
#(
    parameter int CLEAR_CYC = 4,
    parameter int XFER_CYC  = 8,
    parameter int STORE_CYC = 16,
    parameter int CNT_W     = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  nvs_req_t         req,
    input  logic             supply_ok,
    input  logic             tmr_zero,
    output nvs_state_e       state,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             restore_end
);

    localparam logic [CNT_W-1:0] CLEAR_LD = CNT_W'(CLEAR_CYC - 1);
    localparam logic [CNT_W-1:0] XFER_LD  = CNT_W'(XFER_CYC - 1);
    localparam logic [CNT_W-1:0] STORE_LD = CNT_W'(STORE_CYC - 1);

    nvs_state_e state_q, state_d;
    logic       auto_q, auto_d;
    logic       auto_abort;

    // Next-state, timer load and power-up tracking.
    always_comb begin
        state_d    = state_q;
        auto_d     = auto_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        auto_abort = auto_q & ~supply_ok;
        unique case (state_q)
            ST_PWR_WAIT: begin
                if (supply_ok) begin
                    state_d  = ST_CLEAR;
                    auto_d   = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CLEAR_LD;
                end
            end
            ST_IDLE: begin
                if (req.go_store) begin
                    state_d  = ST_STORE;
                    tmr_load = 1'b1;
                    tmr_val  = STORE_LD;
                end else if (req.go_recall) begin
                    state_d  = ST_CLEAR;
                    tmr_load = 1'b1;
                    tmr_val  = CLEAR_LD;
                end else if (req.drop_store) begin
                    state_d = ST_WAIT_REL;
                end
            end
            ST_CLEAR: begin
                if (auto_abort) begin
                    state_d = ST_PWR_WAIT;
                    auto_d  = 1'b0;
                end else if (tmr_zero) begin
                    state_d  = ST_XFER;
                    tmr_load = 1'b1;
                    tmr_val  = XFER_LD;
                end
            end
            ST_XFER: begin
                if (auto_abort) begin
                    state_d = ST_PWR_WAIT;
                    auto_d  = 1'b0;
                end else if (tmr_zero) begin
                    state_d = ST_WAIT_REL;
                    auto_d  = 1'b0;
                end
            end
            ST_STORE: begin
                if (tmr_zero) begin
                    state_d = ST_WAIT_REL;
                end
            end
            ST_WAIT_REL: begin
                if (!req.any_req) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d = ST_PWR_WAIT;
                auto_d  = 1'b0;
            end
        endcase
    end

    // State and power-up flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_PWR_WAIT;
            auto_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            auto_q  <= auto_d;
        end
    end

    // Export the state and the clean end of a power-up recall.
    always_comb begin
        state       = state_q;
        restore_end = (state_q == ST_XFER) & tmr_zero & auto_q & supply_ok;
    end

endmodule

// File: rtl/nvs_seq_top.sv
// Module: nvs_seq_top
// Top of the store/recall sequencer. It joins request qualification, the
// phase timer and the FSM. It decodes the strobes and busy from the state,
// and registers the write-corruption flag.
// Assumes: all inputs are synchronous to clk; phase lengths are at least 1.
module nvs_seq_top
    import nvs_pkg::*;
#(
    parameter int CLEAR_CYC = 4,
    parameter int XFER_CYC  = 8,
    parameter int STORE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sw_store_req,
    input  logic sw_recall_req,
    input  logic hw_store_req,
    input  logic supply_ok,
    input  logic ext_we,
    output logic busy,
    output logic clear_stb,
    output logic recall_stb,
    output logic store_stb,
    output logic write_corrupt
);

    localparam int MAX_CYC = (CLEAR_CYC > XFER_CYC)
                           ? ((CLEAR_CYC > STORE_CYC) ? CLEAR_CYC : STORE_CYC)
                           : ((XFER_CYC > STORE_CYC) ? XFER_CYC : STORE_CYC);
    localparam int CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    nvs_req_t         req;
    nvs_state_e       state;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             restore_end;
    logic             corrupt_q;

    nvs_req_qual u_req (
        .sw_store_req  (sw_store_req),
        .sw_recall_req (sw_recall_req),
        .hw_store_req  (hw_store_req),
        .supply_ok     (supply_ok),
        .req           (req)
    );

    nvs_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    nvs_fsm #(
        .CLEAR_CYC (CLEAR_CYC),
        .XFER_CYC  (XFER_CYC),
        .STORE_CYC (STORE_CYC),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (req),
        .supply_ok   (supply_ok),
        .tmr_zero    (tmr_zero),
        .state       (state),
        .tmr_load    (tmr_load),
        .tmr_val     (tmr_val),
        .restore_end (restore_end)
    );

    // Capture a write active in the final power-up transfer cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corrupt_q <= 1'b0;
        end else begin
            corrupt_q <= restore_end & ext_we;
        end
    end

    // Decode strobes and busy straight from the state.
    always_comb begin
        clear_stb     = (state == ST_CLEAR);
        recall_stb    = (state == ST_XFER);
        store_stb     = (state == ST_STORE);
        busy          = (state == ST_PWR_WAIT) | clear_stb | recall_stb | store_stb;
        write_corrupt = corrupt_q;
    end

endmodule

// File: rtl/nvs_seq_chk.sv
// Module: nvs_seq_chk
// Checker for nvs_seq_top, attached through bind. It watches only the top's
// ports.
// Assumes: inputs change away from the rising clock edge.
module nvs_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_store_req,
    input logic sw_recall_req,
    input logic hw_store_req,
    input logic supply_ok,
    input logic ext_we,
    input logic busy,
    input logic clear_stb,
    input logic recall_stb,
    input logic store_stb,
    input logic write_corrupt
);

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({clear_stb, recall_stb, store_stb})); // R11

    AST_STB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_stb | recall_stb | store_stb) |-> busy); // R11

    AST_XFER_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(recall_stb) |-> $past(clear_stb)); // R9

    AST_CLR_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clear_stb) |-> (recall_stb | (busy & !store_stb))); // R3

    AST_STORE_SUPPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_stb) |-> $past(supply_ok)); // R4

    AST_STORE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(store_stb) |-> $past(sw_store_req | hw_store_req)); // R10

    AST_WC_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        write_corrupt |-> ($past(recall_stb) & $past(ext_we) & !busy)); // R5

    AST_WC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        write_corrupt |=> !write_corrupt); // R5

    AST_RECALL_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_stb | recall_stb) |=> !store_stb); // R9

    AST_RECALL_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy & sw_recall_req & !clear_stb) |=> !$rose(clear_stb)); // R8

endmodule

bind nvs_seq_top nvs_seq_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sw_store_req  (sw_store_req),
    .sw_recall_req (sw_recall_req),
    .hw_store_req  (hw_store_req),
    .supply_ok     (supply_ok),
    .ext_we        (ext_we),
    .busy          (busy),
    .clear_stb     (clear_stb),
    .recall_stb    (recall_stb),
    .store_stb     (store_stb),
    .write_corrupt (write_corrupt)
);

// File: tb/test_nvs_seq_top.sv
// Scoreboard bench. The driver applies inputs on the falling edge and
// queues the output word expected after the next rising edge. The monitor
// pops that word after each rising edge and compares.
module test_nvs_seq_top;

    localparam int CLEAR_CYC = 3;
    localparam int XFER_CYC  = 4;
    localparam int STORE_CYC = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_store_req = 1'b0, sw_recall_req = 1'b0, hw_store_req = 1'b0;
    logic supply_ok = 1'b0, ext_we = 1'b0;
    logic busy, clear_stb, recall_stb, store_stb, write_corrupt;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    typedef struct {
        logic [4:0] val;   // {busy, clear, recall, store, corrupt}
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;

    nvs_seq_top #(
        .CLEAR_CYC (CLEAR_CYC),
        .XFER_CYC  (XFER_CYC),
        .STORE_CYC (STORE_CYC)
    ) i_nvs_seq_top (
        .clk           (clk),
        .rst_n         (rst_n),
        .sw_store_req  (sw_store_req),
        .sw_recall_req (sw_recall_req),
        .hw_store_req  (hw_store_req),
        .supply_ok     (supply_ok),
        .ext_we        (ext_we),
        .busy          (busy),
        .clear_stb     (clear_stb),
        .recall_stb    (recall_stb),
        .store_stb     (store_stb),
        .write_corrupt (write_corrupt)
    );

    // Driver: inputs {sw_store, sw_recall, hw_store, supply, we} for n cycles.
    task automatic cyc(input logic [4:0] in_v, input logic [4:0] ex,
                       input string tag, input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {sw_store_req, sw_recall_req, hw_store_req, supply_ok, ext_we} = in_v;
            sb_q.push_back('{val: ex, tag: tag});
        end
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [4:0] act;
                e   = sb_q.pop_front();
                act = {busy, clear_stb, recall_stb, store_stb, write_corrupt};
                n_tests++;
                if (act !== e.val) begin
                    n_fail++;
                    $display("FAIL %s: outputs act=%b exp=%b", e.tag, act, e.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(4 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: act=timeout exp=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        cyc(5'b00000, 5'b10000, "R1", 3);
        rst_n = 1'b1;
        // R2 waiting for supply
        cyc(5'b00000, 5'b10000, "R2", 2);
        // R3 supply drop during clear phase of power-up recall
        cyc(5'b00010, 5'b11000, "R3", 2);
        cyc(5'b00000, 5'b10000, "R3", 2);
        // R2/R3 full restart: clear then transfer
        cyc(5'b00010, 5'b11000, "R3", 3);
        cyc(5'b00010, 5'b10100, "R2", 4);
        // R5 write active in last transfer cycle
        cyc(5'b00011, 5'b00001, "R5", 1);
        cyc(5'b00010, 5'b00000, "R5", 1);
        // R6 software store, request held high
        cyc(5'b10010, 5'b10010, "R6", 5);
        // R7 held request does not retrigger
        cyc(5'b10010, 5'b00000, "R7", 3);
        cyc(5'b00010, 5'b00000, "R7", 1);
        cyc(5'b10010, 5'b10010, "R6", 1);
        // R8 recall pulse during store is dropped
        cyc(5'b01010, 5'b10010, "R8", 1);
        cyc(5'b00010, 5'b10010, "R8", 3);
        cyc(5'b00010, 5'b00000, "R8", 3);
        // R9 software recall, write at end gives no corrupt flag
        cyc(5'b01010, 5'b11000, "R9", 3);
        cyc(5'b00010, 5'b10100, "R9", 4);
        cyc(5'b00011, 5'b00000, "R9", 1);
        cyc(5'b00010, 5'b00000, "R9", 1);
        // R9 repeated recall
        cyc(5'b01010, 5'b11000, "R9", 1);
        cyc(5'b00010, 5'b11000, "R9", 2);
        cyc(5'b00010, 5'b10100, "R9", 4);
        cyc(5'b00010, 5'b00000, "R9", 2);
        // R4 hardware store with supply low is refused, not replayed
        cyc(5'b00100, 5'b00000, "R4", 3);
        cyc(5'b00110, 5'b00000, "R4", 2);
        cyc(5'b00010, 5'b00000, "R4", 1);
        // R10 hardware store runs the same store
        cyc(5'b00110, 5'b10010, "R10", 5);
        cyc(5'b00010, 5'b00000, "R10", 2);
        // R10 store beats recall
        cyc(5'b11010, 5'b10010, "R10", 1);
        cyc(5'b00010, 5'b10010, "R10", 4);
        cyc(5'b00010, 5'b00000, "R10", 2);
        // R4 software store with supply low
        cyc(5'b10000, 5'b00000, "R4", 2);
        cyc(5'b00000, 5'b00000, "R4", 2);
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule